// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening condition of an I2C transfer for a bus master. Software sets a start bit in a five-bit command register. The block checks that both open-drain lines are idle and times a first interval with a baud down-counter. It then pulls SDA low while SCL stays high, and times a second interval. At the end it clears the start bit, pulses a completion interrupt and leaves SDA held low, so the data phase can follow.

The block watches the bus during the sequence. If it sees a line low where the bus should be idle, it raises a sticky bus-collision flag and drops back to idle with both lines released. While a sequence runs, writes to the transmit buffer raise a sticky write-collision flag and change nothing, and command writes are refused, so commands cannot be queued. Each line is driven through a drive-low enable, and the level of each line is read back on its own input.

Top module: `i2c_start_gen`

## Requirements
- R1: A synchronous reset leaves all flags clear, the command register and buffer at zero, both line drivers released and the block idle.
- R2: A command write with bit 0 (start) set while idle begins a sequence only if sdaIn and sclIn are both high. If either is low, busColFlag is set, startEn (command bit 0) stays 0 and SDA is not driven.
- R3: After an accepted start, the first interval lasts reloadVal[6:0]+1 clock cycles counted from the command-write edge. When it ends, sdaDrvLow asserts and startSeen is high for exactly one cycle.
- R4: The second interval lasts reloadVal[7:0]+1 cycles after SDA goes low. At its end startEn clears, doneIrq is high for exactly one cycle, and sdaDrvLow stays asserted.
- R5: If sclIn is seen low during the first interval, or sdaIn is low when that interval ends, busColFlag is set, the sequence aborts to idle, startEn clears, SDA is released and startSeen never pulses.
- R6: A buffer write while a sequence runs sets wrColFlag and leaves bufData unchanged. A buffer write while idle loads bufData and leaves wrColFlag alone.
- R7: While a sequence runs, command writes to all five bits (start, repeated start, stop, receive enable, acknowledge enable) are ignored. While idle, bits 4..1 are stored as written.
- R8: wrColFlag and busColFlag stay set until their own clear strobe (wrColClr, busColClr) is pulsed. The clear then takes them to 0.
- R9: The block never asserts sclDrvLow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reloadVal | input | 8 | Baud reload value |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 5 | Command write data, bit 0 = start |
| bufWrEn | input | 1 | Transmit buffer write strobe |
| bufWrData | input | 8 | Transmit buffer write data |
| wrColClr | input | 1 | Clears the write-collision flag |
| busColClr | input | 1 | Clears the bus-collision flag |
| sdaIn | input | 1 | Sampled SDA level |
| sclIn | input | 1 | Sampled SCL level |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| cmdReg | output | 5 | Command register readback |
| startEn | output | 1 | Start bit, high while a sequence runs |
| bufData | output | 8 | Transmit buffer contents |
| startSeen | output | 1 | One-cycle start-detected status |
| doneIrq | output | 1 | One-cycle completion interrupt |
| wrColFlag | output | 1 | Sticky write-collision flag |
| busColFlag | output | 1 | Sticky bus-collision flag |

## Verification
The bench checks the edge counts of both intervals, including reload values of zero and with bit 7 set. A design that loaded the full reload value into the first interval, or was off by one in either interval, would move the SDA edge or the interrupt by a cycle, and the bench would see it. SCL is pulled low at random points in the first interval, including its last cycle, to catch a design that misses the abort or still pulses startSeen. Buffer and command writes are injected at random points in the sequence, which exposes a design that corrupts the buffer or lets a queued command bit through.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } startState_t;

  typedef struct packed {
    logic loadShort;
    logic loadFull;
    logic countEn;
    logic setStart;
    logic clrStart;
    logic driveSda;
    logic releaseSda;
    logic setSeen;
    logic setDone;
    logic setBusCol;
  } startStrobes_t;
endpackage

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdWrEn,
  input  logic          cmdStartBit,
  input  logic          sdaIn,
  input  logic          sclIn,
  input  logic          cntZero,
  output logic          busy,
  output startStrobes_t strobes
);
  startState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdWrEn && cmdStartBit) begin
          if (sdaIn && sclIn) begin
            strobes.loadShort = 1'b1;
            strobes.setStart  = 1'b1;
            stateNext         = ST_FIRST;
          end else begin
            strobes.setBusCol = 1'b1;
          end
        end
      end
      ST_FIRST: begin
        if (!sclIn || (cntZero && !sdaIn)) begin
          strobes.setBusCol  = 1'b1;
          strobes.releaseSda = 1'b1;
          strobes.clrStart   = 1'b1;
          stateNext          = ST_IDLE;
        end else if (cntZero) begin
          strobes.loadFull = 1'b1;
          strobes.driveSda = 1'b1;
          strobes.setSeen  = 1'b1;
          stateNext        = ST_SECOND;
        end else begin
          strobes.countEn = 1'b1;
        end
      end
      ST_SECOND: begin
        if (cntZero) begin
          strobes.clrStart = 1'b1;
          strobes.setDone  = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strobes.countEn = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R3: SDA is pulled only after the first interval has run out
  a_r3_drive_on_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.driveSda |-> cntZero && state == ST_FIRST);
  // R5: any abort returns the machine to idle on the next cycle
  a_r5_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && strobes.setBusCol) |=> !busy);
endmodule

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int CMD_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  startStrobes_t       strobes,
  input  logic                busy,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                cmdWrEn,
  input  logic [CMD_W-1:0]    cmdWrData,
  input  logic                bufWrEn,
  input  logic [DATA_W-1:0]   bufWrData,
  input  logic                wrColClr,
  input  logic                busColClr,
  output logic                cntZero,
  output logic                sdaDrvLow,
  output logic                sclDrvLow,
  output logic [CMD_W-1:0]    cmdReg,
  output logic [DATA_W-1:0]   bufData,
  output logic                startSeen,
  output logic                doneIrq,
  output logic                wrColFlag,
  output logic                busColFlag
);
  localparam int SHORT_W = RELOAD_W - 1;

  logic [RELOAD_W-1:0] baudCnt;

  always_ff @(posedge clk) begin
    if (rst)                    baudCnt <= '0;
    else if (strobes.loadShort) baudCnt <= {1'b0, reloadVal[SHORT_W-1:0]};
    else if (strobes.loadFull)  baudCnt <= reloadVal;
    else if (strobes.countEn)   baudCnt <= baudCnt - 1'b1;
  end
  assign cntZero = (baudCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                   cmdReg[0] <= 1'b0;
    else if (strobes.clrStart) cmdReg[0] <= 1'b0;
    else if (strobes.setStart) cmdReg[0] <= 1'b1;
  end

  generate
    for (genvar b = 1; b < CMD_W; b++) begin : g_cmdBit
      always_ff @(posedge clk) begin
        if (rst)                   cmdReg[b] <= 1'b0;
        else if (cmdWrEn && !busy) cmdReg[b] <= cmdWrData[b];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                   bufData <= '0;
    else if (bufWrEn && !busy) bufData <= bufWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdaDrvLow  <= 1'b0;
      startSeen  <= 1'b0;
      doneIrq    <= 1'b0;
      wrColFlag  <= 1'b0;
      busColFlag <= 1'b0;
    end else begin
      if (strobes.driveSda)        sdaDrvLow <= 1'b1;
      else if (strobes.releaseSda) sdaDrvLow <= 1'b0;
      startSeen <= strobes.setSeen;
      doneIrq   <= strobes.setDone;
      if (bufWrEn && busy) wrColFlag <= 1'b1;
      else if (wrColClr)   wrColFlag <= 1'b0;
      if (strobes.setBusCol) busColFlag <= 1'b1;
      else if (busColClr)    busColFlag <= 1'b0;
    end
  end

  assign sclDrvLow = 1'b0;

  a_r3_seen_pulse: assert property (@(posedge clk) disable iff (rst)
    startSeen |=> !startSeen);
  a_r3_seen_sda: assert property (@(posedge clk) disable iff (rst)
    startSeen |-> sdaDrvLow);
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneIrq |=> !doneIrq);
  a_r4_done_state: assert property (@(posedge clk) disable iff (rst)
    doneIrq |-> !cmdReg[0] && sdaDrvLow);
  a_r5_collision_release: assert property (@(posedge clk) disable iff (rst)
    (busy && strobes.setBusCol) |=> busColFlag && !sdaDrvLow && !cmdReg[0]);
  a_r6_buf_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && bufWrEn) |=> $stable(bufData) && wrColFlag);
  a_r7_cmd_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && cmdWrEn) |=> $stable(cmdReg[CMD_W-1:1]));
  a_r8_buscol_sticky: assert property (@(posedge clk) disable iff (rst)
    (busColFlag && !busColClr) |=> busColFlag);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int CMD_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                cmdWrEn,
  input  logic [CMD_W-1:0]    cmdWrData,
  input  logic                bufWrEn,
  input  logic [DATA_W-1:0]   bufWrData,
  input  logic                wrColClr,
  input  logic                busColClr,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaDrvLow,
  output logic                sclDrvLow,
  output logic [CMD_W-1:0]    cmdReg,
  output logic                startEn,
  output logic [DATA_W-1:0]   bufData,
  output logic                startSeen,
  output logic                doneIrq,
  output logic                wrColFlag,
  output logic                busColFlag
);
  startStrobes_t strobes;
  logic busy;
  logic cntZero;

  i2c_start_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdWrEn    (cmdWrEn),
    .cmdStartBit(cmdWrData[0]),
    .sdaIn      (sdaIn),
    .sclIn      (sclIn),
    .cntZero    (cntZero),
    .busy       (busy),
    .strobes    (strobes)
  );

  i2c_start_dp #(
    .RELOAD_W(RELOAD_W),
    .CMD_W   (CMD_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .busy      (busy),
    .reloadVal (reloadVal),
    .cmdWrEn   (cmdWrEn),
    .cmdWrData (cmdWrData),
    .bufWrEn   (bufWrEn),
    .bufWrData (bufWrData),
    .wrColClr  (wrColClr),
    .busColClr (busColClr),
    .cntZero   (cntZero),
    .sdaDrvLow (sdaDrvLow),
    .sclDrvLow (sclDrvLow),
    .cmdReg    (cmdReg),
    .bufData   (bufData),
    .startSeen (startSeen),
    .doneIrq   (doneIrq),
    .wrColFlag (wrColFlag),
    .busColFlag(busColFlag)
  );

  assign startEn = cmdReg[0];

  // R9: this block never holds the clock line
  a_r9_scl_free: assert property (@(posedge clk) disable iff (rst) !sclDrvLow);
endmodule

// File: tb/i2c_start_gen_tb.sv
module i2c_start_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reloadVal = '0;
  logic       cmdWrEn = 1'b0;
  logic [4:0] cmdWrData = '0;
  logic       bufWrEn = 1'b0;
  logic [7:0] bufWrData = '0;
  logic       wrColClr = 1'b0;
  logic       busColClr = 1'b0;
  logic       extSdaLow = 1'b0;
  logic       extSclLow = 1'b0;
  logic       sdaDrvLow, sclDrvLow, startEn, startSeen, doneIrq, wrColFlag, busColFlag;
  logic [4:0] cmdReg;
  logic [7:0] bufData;
  logic       sdaIn, sclIn;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int unsigned seedVal = 32'd1234;

  assign sdaIn = !(sdaDrvLow || extSdaLow);
  assign sclIn = !(sclDrvLow || extSclLow);

  always #2 clk = ~clk;

  i2c_start_gen u_dut (
    .clk(clk), .rst(rst), .reloadVal(reloadVal), .cmdWrEn(cmdWrEn),
    .cmdWrData(cmdWrData), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .wrColClr(wrColClr), .busColClr(busColClr), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaDrvLow(sdaDrvLow), .sclDrvLow(sclDrvLow), .cmdReg(cmdReg),
    .startEn(startEn), .bufData(bufData), .startSeen(startSeen),
    .doneIrq(doneIrq), .wrColFlag(wrColFlag), .busColFlag(busColFlag)
  );

  function automatic int firstLen(input logic [7:0] r);
    return int'(r[6:0]) + 1;
  endfunction
  function automatic int totalLen(input logic [7:0] r);
    return int'(r[6:0]) + int'(r) + 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    extSdaLow = 1'b0;
    extSclLow = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  // Runs one start sequence; sclGlitch >= 0 pulls SCL low on that k; injectK >= 0 adds writes
  task automatic runStart(input logic [7:0] r, input logic [3:0] upper,
                          input int sclGlitch, input int injectK);
    int first;
    int total;
    bit aborted;
    bit seenAny;
    logic [7:0] bufBefore;
    first = firstLen(r);
    total = totalLen(r);
    aborted = 1'b0;
    seenAny = 1'b0;
    bufBefore = bufData;
    reloadVal = r;
    cmdWrData = {upper, 1'b1};
    cmdWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      extSclLow = 1'b0;
      bufWrEn = 1'b0;
      cmdWrEn = 1'b0;
      if (startSeen) seenAny = 1'b1;
      if (aborted) begin
        chk("R5 busCol", busColFlag, 1);
        chk("R5 sda released", sdaDrvLow, 0);
        chk("R5 startEn", startEn, 0);
        chk("R5 no seen", seenAny, 0);
        break;
      end
      chk("R3 sdaDrvLow", sdaDrvLow, (k >= first && k <= total + 1));
      chk("R3 startSeen", startSeen, (k == first));
      chk("R4 doneIrq", doneIrq, (k == total));
      chk("R4 startEn", startEn, (k < total));
      chk("R7 cmd upper", cmdReg[4:1], upper);
      chk("R6 buf stable", bufData, bufBefore);
      chk("R9 scl", sclDrvLow, 0);
      if (injectK >= 0 && k == injectK + 1) chk("R6 wrCol", wrColFlag, 1);
      if (k == sclGlitch && k < first) begin
        extSclLow = 1'b1;
        aborted = 1'b1;
      end
      if (k == injectK && k < total) begin
        bufWrEn = 1'b1;
        bufWrData = 8'($urandom);
        cmdWrEn = 1'b1;
        cmdWrData = 5'($urandom);
      end
      tick();
    end
    extSclLow = 1'b0;
    bufWrEn = 1'b0;
    cmdWrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(seedVal));
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 sda", sdaDrvLow, 0);
    chk("R1 scl", sclDrvLow, 0);
    chk("R1 cmd", cmdReg, 0);
    chk("R1 buf", bufData, 0);
    chk("R1 flags", {startSeen, doneIrq, wrColFlag, busColFlag}, 0);

    // R6 idle buffer write
    bufWrData = 8'hA5;
    bufWrEn = 1'b1;
    tick();
    bufWrEn = 1'b0;
    chk("R6 idle buf", bufData, 8'hA5);
    chk("R6 idle wrCol", wrColFlag, 0);

    // R7 idle command write without start
    cmdWrData = 5'b10100;
    cmdWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0;
    chk("R7 idle cmd", cmdReg, 5'b10100);

    // R2 SDA low at start
    extSdaLow = 1'b1;
    cmdWrData = 5'b00011;
    cmdWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0;
    extSdaLow = 1'b0;
    chk("R2 busCol sda", busColFlag, 1);
    chk("R2 startEn", startEn, 0);
    chk("R2 sda", sdaDrvLow, 0);
    for (int i = 0; i < 5; i++) tick();
    chk("R8 sticky busCol", busColFlag, 1);
    busColClr = 1'b1;
    tick();
    busColClr = 1'b0;
    chk("R8 clear busCol", busColFlag, 0);

    // R2 SCL low at start
    extSclLow = 1'b1;
    cmdWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0;
    extSclLow = 1'b0;
    chk("R2 busCol scl", busColFlag, 1);
    chk("R2 startEn scl", startEn, 0);

    // Directed interval corners: R3 R4
    doReset();
    runStart(8'h00, 4'h0, -1, -1);
    doReset();
    runStart(8'h80, 4'h5, -1, -1);
    doReset();
    runStart(8'hFF, 4'hA, -1, 3);
    chk("R8 sticky wrCol", wrColFlag, 1);
    wrColClr = 1'b1;
    tick();
    wrColClr = 1'b0;
    chk("R8 clear wrCol", wrColFlag, 0);

    // R5 SCL low on last cycle of first interval
    doReset();
    runStart(8'h04, 4'h3, 4, -1);
    doReset();
    runStart(8'h07, 4'h1, 0, -1);

    // Constrained random mix
    for (int n = 0; n < 24; n++) begin
      logic [7:0] r;
      int glitch;
      int inj;
      r = 8'($urandom_range(0, 255));
      glitch = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, int'(r[6:0]))) : -1;
      inj = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, totalLen(r) - 1)) : -1;
      if (glitch >= 0 && inj >= glitch) inj = -1;
      doReset();
      runStart(r, 4'($urandom), glitch, inj);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule